// File: doc/BRIEF.md
# UART Control Register File with Bus Slave Port

This block is the software-visible control surface of a small serial port. A host processor reaches it over a 32-bit classic Wishbone slave port. It holds five word-aligned registers: a clock-frequency word, a read-only view of the last received byte, the byte to transmit, a receive-interrupt enable, and a transmit-go flag. The serial shift engines sit beside it. They read the configuration outputs, feed the received byte in, and strobe a clear input when a transmission completes.

Two registers have side effects. A bus read of the received-byte register raises a one-cycle pulse, which the receive engine uses to retire its pending interrupt. The transmit-go flag is set by software and cleared only by hardware. Software therefore polls it to learn when a transfer is done. The strobe is qualified by a fixed base window on the upper address bits, so accesses outside the window are not answered.

Top module: `uart_regs_top`

## Requirements
- R1: After reset the outputs are freqWord = 1000000 (0x000F4240), txByte = 0, irqEnable = 1 and txGo = 0. The reset is active-low and synchronous.
- R2: A write to the frequency word (offset 0x00) updates only the byte lanes whose wbSel bit is 1 (lane n is bits 8n+7:8n). A write to the transmit byte (0x08, bits 7:0) or to the interrupt enable (0x0C, bit 0) takes effect only when wbSel[0] is 1. Every write is visible on the core outputs and on readback.
- R3: A read of offset 0x04 returns rxByte in bits 7:0. Writes to 0x04 have no effect. Reserved bits of offsets 0x04, 0x08, 0x0C and 0x10 read as 0.
- R4: Writing 1 to bit 0 of offset 0x10 (with wbSel[0] = 1) sets txGo, and writing 0 leaves it unchanged. txGo returns to 0 on the cycle after txDoneClr is high. If txDoneClr and a write of 1 arrive in the same cycle, the flag ends at 0.
- R5: Each accepted read of offset 0x04 produces exactly one rxReadPulse cycle, which coincides with its wbAck. Writes to that offset and reads of other offsets produce no pulse.
- R6: Each accepted strobe is acknowledged by wbAck high for exactly one cycle, on the clock edge after the strobe is presented. wbStall, wbErr and wbRty are always 0.
- R7: A strobe whose address bits 31:8 differ from 0x300000 gets no acknowledge and changes no register.
- R8: Inside the window, an address that is not one of the five word offsets is acknowledged, reads as 0 and ignores writes. This covers 0x14 to 0xFC and any address with bits 1:0 nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | 32 | Byte address |
| wbDatIn | input | 32 | Write data |
| wbSel | input | 4 | Byte-lane selects |
| wbAck | output | 1 | Acknowledge |
| wbStall | output | 1 | Stall, always 0 |
| wbErr | output | 1 | Error, always 0 |
| wbRty | output | 1 | Retry, always 0 |
| wbDatOut | output | 32 | Read data, valid with wbAck |
| freqWord | output | 32 | Clock frequency word to the core |
| txByte | output | 8 | Byte to transmit |
| irqEnable | output | 1 | Receive interrupt enable |
| txGo | output | 1 | Transmit-go flag |
| rxByte | input | 8 | Byte from the receive engine |
| txDoneClr | input | 1 | Hardware clear for txGo |
| rxReadPulse | output | 1 | One-cycle pulse on a read of the received byte |

## Verification
Every result of an access lands on the clock edge after the strobe is first presented. That edge registers the acknowledge, the read data, the receive-read pulse and the register update together. The bench drives each strobe just after a falling edge and samples on the following falling edges. It counts how many acknowledge and pulse cycles appear in a four-cycle window and notes in which cycle the acknowledge arrived. The txGo clear acts at the next edge, so the bench reads txGo one falling edge after it asserts txDoneClr. Accesses outside the window are checked by seeing no acknowledge in that window and by reading the core outputs afterwards.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 32;
  localparam int WIN_LSB    = 8;
  localparam int WORD_IDX_W = WIN_LSB - 2;
  localparam int NUM_REGS   = 5;
  localparam int LANES      = DATA_W / 8;

  localparam logic [WORD_IDX_W-1:0] IDX_FREQ = 'd0;
  localparam logic [WORD_IDX_W-1:0] IDX_RX   = 'd1;
  localparam logic [WORD_IDX_W-1:0] IDX_TX   = 'd2;
  localparam logic [WORD_IDX_W-1:0] IDX_IE   = 'd3;
  localparam logic [WORD_IDX_W-1:0] IDX_GO   = 'd4;

  typedef struct packed {
    logic                  accept;
    logic                  write;
    logic                  aligned;
    logic [WORD_IDX_W-1:0] word;
  } regStrobe_t;
endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter logic [ADDR_W-WIN_LSB-1:0] BASE_HI = 24'h300000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  output regStrobe_t        strobe,
  output logic              wbAck
);
  logic inWindow;
  logic ackQ;

  assign inWindow = (wbAdr[ADDR_W-1:WIN_LSB] == BASE_HI);

  always_comb begin
    strobe.accept  = wbCyc && wbStb && inWindow && !ackQ;
    strobe.write   = wbWe;
    strobe.aligned = (wbAdr[1:0] == 2'b00);
    strobe.word    = wbAdr[WIN_LSB-1:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= strobe.accept;
  end

  assign wbAck = ackQ;

  // R6: an acknowledge only follows a presented strobe
  a_r6_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbAck) |-> $past(wbCyc && wbStb));

  // R7: strobes outside the window are never answered
  a_r7_no_ack_outside: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbStb && (wbAdr[ADDR_W-1:WIN_LSB] != BASE_HI)) |=> !wbAck);
endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] FREQ_RESET = 32'd1000000
)(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wbDatIn,
  input  logic [LANES-1:0]  wbSel,
  input  logic [7:0]        rxByte,
  input  logic              txDoneClr,
  output logic [DATA_W-1:0] wbDatOut,
  output logic [DATA_W-1:0] freqWord,
  output logic [7:0]        txByte,
  output logic              irqEnable,
  output logic              txGo,
  output logic              rxReadPulse
);
  logic              mapped;
  logic              wrHit;
  logic              rdHit;
  logic [DATA_W-1:0] freqReg;
  logic [7:0]        txReg;
  logic              ieReg;
  logic              goReg;
  logic [DATA_W-1:0] readMux;
  logic [DATA_W-1:0] rdQ;
  logic              pulseQ;

  assign mapped = strobe.aligned && (strobe.word < WORD_IDX_W'(NUM_REGS));
  assign wrHit  = strobe.accept && strobe.write && mapped;
  assign rdHit  = strobe.accept && !strobe.write && mapped;

  for (genvar lane = 0; lane < LANES; lane++) begin : gFreqLane
    always_ff @(posedge clk) begin
      if (!rstN)
        freqReg[lane*8 +: 8] <= FREQ_RESET[lane*8 +: 8];
      else if (wrHit && strobe.word == IDX_FREQ && wbSel[lane])
        freqReg[lane*8 +: 8] <= wbDatIn[lane*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= 8'd0;
      ieReg <= 1'b1;
      goReg <= 1'b0;
    end else begin
      if (wrHit && strobe.word == IDX_TX && wbSel[0]) txReg <= wbDatIn[7:0];
      if (wrHit && strobe.word == IDX_IE && wbSel[0]) ieReg <= wbDatIn[0];
      if (txDoneClr)
        goReg <= 1'b0;
      else if (wrHit && strobe.word == IDX_GO && wbSel[0] && wbDatIn[0])
        goReg <= 1'b1;
    end
  end

  always_comb begin
    readMux = '0;
    if (mapped) begin
      case (strobe.word)
        IDX_FREQ: readMux = freqReg;
        IDX_RX:   readMux[7:0] = rxByte;
        IDX_TX:   readMux[7:0] = txReg;
        IDX_IE:   readMux[0] = ieReg;
        IDX_GO:   readMux[0] = goReg;
        default:  readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ    <= '0;
      pulseQ <= 1'b0;
    end else begin
      rdQ    <= (strobe.accept && !strobe.write) ? readMux : '0;
      pulseQ <= rdHit && (strobe.word == IDX_RX);
    end
  end

  assign wbDatOut    = rdQ;
  assign rxReadPulse = pulseQ;
  assign freqWord    = freqReg;
  assign txByte      = txReg;
  assign irqEnable   = ieReg;
  assign txGo        = goReg;

  // R4: hardware clear dominates any same-cycle set
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    txDoneClr |=> !txGo);

  // R2: the frequency word moves only on an accepted write
  a_r2_freq_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.accept && strobe.write) |=> $stable(freqWord));

  // R5: the pulse never lasts two cycles
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    rxReadPulse |=> !rxReadPulse);
endmodule

// File: rtl/uart_regs_top.sv
module uart_regs_top
  import uart_regs_pkg::*;
#(
  parameter logic [ADDR_W-WIN_LSB-1:0] BASE_HI    = 24'h300000,
  parameter logic [DATA_W-1:0]         FREQ_RESET = 32'd1000000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0] wbDatIn,
  input  logic [LANES-1:0]  wbSel,
  output logic              wbAck,
  output logic              wbStall,
  output logic              wbErr,
  output logic              wbRty,
  output logic [DATA_W-1:0] wbDatOut,
  output logic [DATA_W-1:0] freqWord,
  output logic [7:0]        txByte,
  output logic              irqEnable,
  output logic              txGo,
  input  logic [7:0]        rxByte,
  input  logic              txDoneClr,
  output logic              rxReadPulse
);
  regStrobe_t strobe;

  uart_regs_ctrl #(.BASE_HI(BASE_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .strobe(strobe), .wbAck(wbAck)
  );

  uart_regs_dp #(.FREQ_RESET(FREQ_RESET)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wbDatIn(wbDatIn), .wbSel(wbSel),
    .rxByte(rxByte), .txDoneClr(txDoneClr), .wbDatOut(wbDatOut),
    .freqWord(freqWord), .txByte(txByte), .irqEnable(irqEnable),
    .txGo(txGo), .rxReadPulse(rxReadPulse)
  );

  assign wbStall = 1'b0;
  assign wbErr   = 1'b0;
  assign wbRty   = 1'b0;

  // R5: the receive-read pulse always rides on an acknowledge
  a_r5_pulse_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    rxReadPulse |-> wbAck);
endmodule

// File: tb/uart_regs_top_test.sv
module uart_regs_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [31:0] wbAdr = '0, wbDatIn = '0;
  logic [3:0]  wbSel = '0;
  logic        wbAck, wbStall, wbErr, wbRty;
  logic [31:0] wbDatOut, freqWord;
  logic [7:0]  txByte;
  logic        irqEnable, txGo;
  logic [7:0]  rxByte = '0;
  logic        txDoneClr = 1'b0;
  logic        rxReadPulse;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  uart_regs_top uut (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatIn(wbDatIn), .wbSel(wbSel), .wbAck(wbAck),
    .wbStall(wbStall), .wbErr(wbErr), .wbRty(wbRty), .wbDatOut(wbDatOut),
    .freqWord(freqWord), .txByte(txByte), .irqEnable(irqEnable), .txGo(txGo),
    .rxByte(rxByte), .txDoneClr(txDoneClr), .rxReadPulse(rxReadPulse)
  );

  always #5 clk = ~clk;

  localparam logic [31:0] BASE = 32'h3000_0000;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one bus access; reports acks, pulses, cycle of first ack and read data
  task automatic access(input logic [31:0] adr, input logic we, input logic [31:0] dat,
                        input logic [3:0] sel, output logic [31:0] rdata,
                        output int acks, output int pulses, output int ackAt);
    acks = 0; pulses = 0; ackAt = -1; rdata = '0;
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = we; wbAdr = adr; wbDatIn = dat; wbSel = sel;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rxReadPulse) pulses++;
      if (wbAck) begin
        acks++;
        if (ackAt < 0) begin ackAt = i; rdata = wbDatOut; end
        wbCyc = 0; wbStb = 0; wbWe = 0;
      end
    end
    wbCyc = 0; wbStb = 0; wbWe = 0;
  endtask

  task automatic tReset();
    check(freqWord == 32'd1000000, "R1 freq reset", freqWord, 32'd1000000);
    check(txByte == 8'd0, "R1 tx reset", {24'd0, txByte}, 0);
    check(irqEnable == 1'b1, "R1 ie reset", {31'd0, irqEnable}, 1);
    check(txGo == 1'b0, "R1 go reset", {31'd0, txGo}, 0);
    check({wbStall, wbErr, wbRty} == 3'b000, "R6 tie-offs", {29'd0, wbStall, wbErr, wbRty}, 0);
  endtask

  task automatic tReadback();
    logic [31:0] d; int a, p, at;
    access(BASE + 32'h00, 0, 0, 4'hF, d, a, p, at);
    check(d == 32'd1000000, "R1 freq readback", d, 32'd1000000);
    check(a == 1 && at == 0, "R6 single ack next edge", a, 1);
    access(BASE + 32'h0C, 0, 0, 4'hF, d, a, p, at);
    check(d == 32'd1, "R1 ie readback", d, 1);
  endtask

  task automatic tWrites();
    logic [31:0] d; int a, p, at;
    access(BASE + 32'h00, 1, 32'hAABBCCDD, 4'b0101, d, a, p, at);
    check(freqWord == 32'h00BB42DD, "R2 byte lanes", freqWord, 32'h00BB42DD);
    access(BASE + 32'h00, 0, 0, 4'hF, d, a, p, at);
    check(d == 32'h00BB42DD, "R2 freq readback", d, 32'h00BB42DD);
    access(BASE + 32'h08, 1, 32'hFFFFFF5A, 4'hF, d, a, p, at);
    check(txByte == 8'h5A, "R2 tx write", {24'd0, txByte}, 32'h5A);
    access(BASE + 32'h08, 0, 0, 4'hF, d, a, p, at);
    check(d == 32'h5A, "R3 tx reserved zero", d, 32'h5A);
    access(BASE + 32'h08, 1, 32'h11, 4'b1110, d, a, p, at);
    check(txByte == 8'h5A, "R2 tx lane0 unselected", {24'd0, txByte}, 32'h5A);
    access(BASE + 32'h0C, 1, 32'hFFFFFFFE, 4'hF, d, a, p, at);
    check(irqEnable == 1'b0, "R2 ie clear", {31'd0, irqEnable}, 0);
  endtask

  task automatic tRx();
    logic [31:0] d; int a, p, at;
    rxByte = 8'hC3;
    access(BASE + 32'h04, 0, 0, 4'hF, d, a, p, at);
    check(d == 32'hC3, "R3 rx read", d, 32'hC3);
    check(p == 1, "R5 one pulse on rx read", p, 1);
    access(BASE + 32'h00, 0, 0, 4'hF, d, a, p, at);
    check(p == 0, "R5 no pulse other read", p, 0);
    access(BASE + 32'h04, 1, 32'hFFFFFFFF, 4'hF, d, a, p, at);
    check(p == 0 && a == 1, "R5 no pulse on rx write", p, 0);
    access(BASE + 32'h04, 0, 0, 4'hF, d, a, p, at);
    check(d == 32'hC3, "R3 rx write ignored", d, 32'hC3);
  endtask

  task automatic tGo();
    logic [31:0] d; int a, p, at;
    access(BASE + 32'h10, 1, 32'h0, 4'hF, d, a, p, at);
    check(txGo == 0, "R4 write 0 no set", {31'd0, txGo}, 0);
    access(BASE + 32'h10, 1, 32'h1, 4'hF, d, a, p, at);
    check(txGo == 1, "R4 set", {31'd0, txGo}, 1);
    access(BASE + 32'h10, 0, 0, 4'hF, d, a, p, at);
    check(d == 32'h1, "R4 poll readback", d, 1);
    access(BASE + 32'h10, 1, 32'h0, 4'hF, d, a, p, at);
    check(txGo == 1, "R4 write 0 ignored", {31'd0, txGo}, 1);
    @(negedge clk); txDoneClr = 1;
    @(negedge clk); txDoneClr = 0;
    check(txGo == 0, "R4 hw clear", {31'd0, txGo}, 0);
    txDoneClr = 1;
    access(BASE + 32'h10, 1, 32'h1, 4'hF, d, a, p, at);
    txDoneClr = 0;
    @(negedge clk);
    check(txGo == 0, "R4 clear wins", {31'd0, txGo}, 0);
  endtask

  task automatic tWindow();
    logic [31:0] d; int a, p, at;
    access(32'h4000_0000, 1, 32'h12345678, 4'hF, d, a, p, at);
    check(a == 0, "R7 no ack outside", a, 0);
    check(freqWord == 32'h00BB42DD, "R7 no write outside", freqWord, 32'h00BB42DD);
    access(32'h3000_0100, 0, 0, 4'hF, d, a, p, at);
    check(a == 0, "R7 no ack neighbour window", a, 0);
  endtask

  task automatic tUnmapped();
    logic [31:0] d; int a, p, at;
    access(BASE + 32'h14, 0, 0, 4'hF, d, a, p, at);
    check(a == 1 && d == 0, "R8 unmapped read", d, 0);
    access(BASE + 32'h18, 1, 32'hFFFFFFFF, 4'hF, d, a, p, at);
    check(a == 1, "R8 unmapped write acked", a, 1);
    check(freqWord == 32'h00BB42DD && txByte == 8'h5A && irqEnable == 0 && txGo == 0,
          "R8 unmapped write no effect", freqWord, 32'h00BB42DD);
    access(BASE + 32'h02, 0, 0, 4'hF, d, a, p, at);
    check(a == 1 && d == 0, "R8 misaligned read", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tReadback();
    tWrites();
    tRx();
    tGo();
    tWindow();
    tUnmapped();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule